// File: doc/BRIEF.md
# Correlating Global-History Branch Predictor

This block predicts the direction of conditional branches for an instruction fetch unit. Fetch presents a branch address, and in the same cycle the block returns a taken or not-taken guess. It also returns the global outcome history that was used for the guess. Internally, a few low address bits are joined with a short shift register of the most recent branch outcomes. The result indexes a table of 2-bit saturating counters. Each address slot therefore owns one counter per possible history pattern, so the path that led to a branch decides which counter speaks for it.

When a branch resolves, the pipeline returns the branch address, the real outcome, and the history snapshot captured at prediction time. That one counter is trained upward or downward. The outcome is then shifted into the global history. With the default parameters, 4 address bits and 2 history bits form a 6-bit index over 64 counters, which is 128 bits of counter state.

Top module: `gcorr_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and the global history is 0, so `pred_taken` is 0 for any address and `pred_hist` is 0.
- R2: The prediction is combinational in the same cycle. The index is `{pred_pc[5:2], history[1:0]}`, and `pred_taken` is 1 exactly when the selected counter is 2 or 3.
- R3: An update with `upd_taken`=1 increments the addressed counter and saturates at 3.
- R4: An update with `upd_taken`=0 decrements the addressed counter and saturates at 0. A counter at 2 still predicts taken after a single not-taken update from 3.
- R5: The update index is `{upd_pc[5:2], upd_hist[1:0]}`. It is built from the supplied snapshot, not from the current global history.
- R6: An update changes only the one addressed counter. The other three counters of the same address slot, and all other slots, keep their values.
- R7: On each update the history becomes `{old_history[0], upd_taken}`, so the newest outcome sits in bit 0. `pred_hist` shows the new value from the next cycle on.
- R8: While `upd_valid` is 0, the values on `upd_pc`, `upd_taken` and `upd_hist` have no effect on the counters or on the history.
- R9: When a prediction and an update hit the same counter in one cycle, the prediction shows the counter value from before the update.
- R10: Address bits outside `[5:2]` do not affect the index, so addresses that agree in bits 5..2 share counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | 32 | Address of the branch being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | 2 | Global history used for this prediction (snapshot for the later update) |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | 2 | History snapshot taken when the branch was predicted |

## Verification
The prediction outputs are combinational, so they are due in the same cycle the address is driven. The bench drives at the falling edge and samples a quarter period later, before the next rising edge. Effects of an update (a counter change or a history shift) appear only after the following rising edge. The bench's model applies each update after it records the expected prediction for that cycle, which also fixes the read-before-write order for a collision in one cycle. Counter states that the current history cannot reach are made visible by first steering the history with two updates to an unrelated slot and then probing.

// File: rtl/gcorr_pkg.sv
package gcorr_pkg;

  // Width of one saturating direction counter.
  localparam int unsigned CTR_W = 2;

  typedef logic [CTR_W-1:0] ctr_t;

  localparam ctr_t CTR_MAX  = ctr_t'((1 << CTR_W) - 1);
  localparam ctr_t CTR_MIN  = '0;
  // Weakly not taken: just below the taken threshold.
  localparam ctr_t CTR_INIT = ctr_t'((1 << (CTR_W - 1)) - 1);

  // Next counter state for a resolved outcome, saturating at both ends.
  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? cur : cur + ctr_t'(1);
    else       nxt = (cur == CTR_MIN) ? cur : cur - ctr_t'(1);
    return nxt;
  endfunction

  // Upper half of the counter range predicts taken.
  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur[CTR_W-1];
  endfunction

endpackage

// File: rtl/gcorr_history.sv
module gcorr_history #(
  parameter int unsigned HIST_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 shift_in,
  output logic [HIST_BITS-1:0] hist_q
);

  logic [HIST_BITS-1:0] hist_d;

  generate
    if (HIST_BITS == 1) begin : g_one
      assign hist_d = shift_in;
    end else begin : g_many
      assign hist_d = {hist_q[HIST_BITS-2:0], shift_in};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  // R7
  hist_newest_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(shift_in));

  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/gcorr_ctr_table.sv
module gcorr_ctr_table
  import gcorr_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  ctr_t             ctr_q [DEPTH];
  logic [DEPTH-1:0] cell_we;

  // Decoded per-cell write strobes, brought out for the checks.
  always_comb begin
    cell_we = '0;
    if (wr_en) cell_we[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n)          ctr_q[i] <= CTR_INIT;
      else if (cell_we[i]) ctr_q[i] <= ctr_next(ctr_q[i], wr_taken);
    end
  end

  // Read returns the registered value: a same-cycle write is not visible.
  assign rd_ctr = ctr_q[rd_idx];

  // R6
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_we));

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell_chk
      // R6
      cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_we[g] |=> $stable(ctr_q[g]));
      // R3
      cell_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_we[g] && wr_taken && ctr_q[g] == CTR_MAX) |=> ctr_q[g] == CTR_MAX);
      // R4
      cell_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_we[g] && !wr_taken && ctr_q[g] == CTR_MIN) |=> ctr_q[g] == CTR_MIN);
      // R3
      cell_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_we[g] && wr_taken && ctr_q[g] != CTR_MAX) |=>
          ctr_q[g] == $past(ctr_q[g]) + ctr_t'(1));
    end
  endgenerate

endmodule

// File: rtl/gcorr_predictor.sv
module gcorr_predictor
  import gcorr_pkg::*;
#(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned PC_LSB    = 2,
  parameter int unsigned ADDR_BITS = 4,
  parameter int unsigned HIST_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      pred_pc,
  output logic                 pred_taken,
  output logic [HIST_BITS-1:0] pred_hist,
  input  logic                 upd_valid,
  input  logic [PC_W-1:0]      upd_pc,
  input  logic                 upd_taken,
  input  logic [HIST_BITS-1:0] upd_hist
);

  localparam int unsigned IDX_W = ADDR_BITS + HIST_BITS;

  logic [HIST_BITS-1:0] ghist_q;
  logic [IDX_W-1:0]     pred_idx;
  logic [IDX_W-1:0]     upd_idx;
  ctr_t                 pred_ctr;

  // Address bits outside the slot field are deliberately dropped.
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc, upd_pc};

  assign pred_idx = {pred_pc[PC_LSB +: ADDR_BITS], ghist_q};
  assign upd_idx  = {upd_pc[PC_LSB +: ADDR_BITS], upd_hist};

  gcorr_history #(
    .HIST_BITS (HIST_BITS)
  ) hist_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_valid),
    .shift_in (upd_taken),
    .hist_q   (ghist_q)
  );

  gcorr_ctr_table #(
    .IDX_W (IDX_W)
  ) table_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (pred_idx),
    .rd_ctr   (pred_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken)
  );

  assign pred_taken = ctr_says_taken(pred_ctr);
  assign pred_hist  = ghist_q;

  // R8
  idle_hist_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> pred_hist == $past(pred_hist));

  // R7
  hist_out_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> pred_hist[0] == $past(upd_taken));

endmodule

// File: tb/gcorr_predictor_tb.sv
module gcorr_predictor_tb_top;

  localparam int CLK_P = 10;

  typedef struct {
    logic [31:0] pc;
    logic        taken;
    logic [1:0]  hist;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken;
  logic [1:0]  pred_hist;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [1:0]  upd_hist = '0;

  int   checks = 0;
  int   errors = 0;
  exp_t sb_q[$];
  int   mdl_ctr [64];
  logic [1:0] mdl_hist = '0;

  always #(CLK_P/2) clk = ~clk;

  gcorr_predictor dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .pred_hist  (pred_hist),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken),
    .upd_hist   (upd_hist)
  );

  // Driver: one cycle of stimulus, expected result pushed before the model updates.
  task automatic step(input logic [31:0] pc, input logic uv, input logic [31:0] upc,
                      input logic ut, input logic [1:0] uh, input string tag);
    exp_t e;
    int   slot;
    @(negedge clk);
    pred_pc   = pc;
    upd_valid = uv;
    upd_pc    = upc;
    upd_taken = ut;
    upd_hist  = uh;
    slot      = int'(pc[5:2]) * 4 + int'(mdl_hist);
    e.pc    = pc;
    e.taken = (mdl_ctr[slot] >= 2);
    e.hist  = mdl_hist;
    e.tag   = tag;
    sb_q.push_back(e);
    if (uv) begin
      slot = int'(upc[5:2]) * 4 + int'(uh);
      if (ut) begin if (mdl_ctr[slot] < 3) mdl_ctr[slot]++; end
      else    begin if (mdl_ctr[slot] > 0) mdl_ctr[slot]--; end
      mdl_hist = {mdl_hist[0], ut};
    end
  endtask

  task automatic probe(input logic [31:0] pc, input string tag);
    step(pc, 1'b0, 32'h0, 1'b0, 2'b00, tag);
  endtask

  task automatic train(input logic [31:0] pc, input logic t, input logic [1:0] h,
                       input int n, input string tag);
    for (int i = 0; i < n; i++) step(32'h0, 1'b1, pc, t, h, tag);
  endtask

  // Steer the global history through two updates to slot 15 (pc 0x3C).
  task automatic set_hist(input logic [1:0] h);
    step(32'h0, 1'b1, 32'h3C, h[1], 2'b00, "R7");
    step(32'h0, 1'b1, 32'h3C, h[0], 2'b00, "R7");
  endtask

  // Monitor: compares a quarter period after each falling edge.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks++;
        if (pred_taken !== e.taken) begin
          errors++;
          $display("FAIL %s pred_taken pc=%h actual=%b expected=%b", e.tag, e.pc, pred_taken, e.taken);
        end
        checks++;
        if (pred_hist !== e.hist) begin
          errors++;
          $display("FAIL %s pred_hist pc=%h actual=%b expected=%b", e.tag, e.pc, pred_hist, e.hist);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl_ctr[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state seen through several slots
    probe(32'h0000_0000, "R1");
    probe(32'h0000_0024, "R1");
    probe(32'hFFFF_FFFC, "R1");

    // R3: climb and saturate counter {slot 4, hist 0}
    train(32'h10, 1'b1, 2'b00, 5, "R3");
    set_hist(2'b00);
    probe(32'h10, "R3");

    // R4: one step down keeps taken, then saturate low, then one step up
    train(32'h10, 1'b0, 2'b00, 1, "R4");
    set_hist(2'b00);
    probe(32'h10, "R4");
    train(32'h10, 1'b0, 2'b00, 5, "R4");
    set_hist(2'b00);
    probe(32'h10, "R4");
    train(32'h10, 1'b1, 2'b00, 1, "R4");
    set_hist(2'b00);
    probe(32'h10, "R4");

    // R2 / R6: only the history-selected counter of slot 6 is trained
    train(32'h18, 1'b1, 2'b10, 2, "R6");
    set_hist(2'b10); probe(32'h18, "R2");
    set_hist(2'b01); probe(32'h18, "R6");
    set_hist(2'b11); probe(32'h18, "R6");
    set_hist(2'b00); probe(32'h18, "R6");

    // R5: the snapshot, not the live history, picks the trained counter
    set_hist(2'b11);
    train(32'h28, 1'b1, 2'b01, 2, "R5");
    set_hist(2'b01); probe(32'h28, "R5");
    set_hist(2'b11); probe(32'h28, "R5");

    // R7: newest outcome enters bit 0
    set_hist(2'b00);
    step(32'h0, 1'b1, 32'h30, 1'b1, 2'b00, "R7");
    probe(32'h30, "R7");
    step(32'h0, 1'b1, 32'h30, 1'b0, 2'b00, "R7");
    probe(32'h30, "R7");

    // R8: update fields without valid change nothing
    step(32'h18, 1'b0, 32'h18, 1'b0, 2'b10, "R8");
    step(32'h18, 1'b0, 32'h18, 1'b0, 2'b10, "R8");
    step(32'h18, 1'b0, 32'h18, 1'b0, 2'b10, "R8");
    set_hist(2'b10); probe(32'h18, "R8");

    // R9: collision in one cycle shows the pre-update value (2 -> 1)
    train(32'h34, 1'b1, 2'b00, 1, "R9");
    set_hist(2'b00);
    step(32'h34, 1'b1, 32'h34, 1'b0, 2'b00, "R9");
    set_hist(2'b00); probe(32'h34, "R9");

    // R10: aliasing through bits outside [5:2]
    train(32'h08, 1'b1, 2'b00, 2, "R10");
    set_hist(2'b00); probe(32'h48, "R10");
    set_hist(2'b00); probe(32'h0B, "R10");
    set_hist(2'b00); probe(32'hFFFF_FF08, "R10");

    // R2: mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      step(a, 1'($urandom % 2), b, 1'($urandom % 2), 2'($urandom % 4), "R2");
    end

    repeat (3) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule